// File: doc/BRIEF.md
# Keyed Output Lock with Point-Function and Corruption Booster

This block sits on one output bit of a protected circuit. It takes the circuit's primary input vector, a key of twice that width and the circuit's unlocked output bit. It drives a locked output bit that equals the unlocked bit only when the key is right. It is purely combinational: no clock, no reset and no stored state. The locked bit follows its inputs with no delay beyond the gates.

Two keyed units produce a flip term each. The two flip terms are XORed, and the result is XORed onto the unlocked bit.

- **Point unit.** It compares the input vector, bit by bit and through fixed XOR/XNOR polarities, with the lower key half. It fires on exactly one input pattern per key half. It is blocked on one hidden pattern.
- **Booster unit.** It flips roughly half of all input patterns, chosen by one tapped input bit against one key bit. It is silenced when the upper key half equals a wired-in secret value.

With this arrangement exactly one key leaves the output intact. Keys that differ from it only in the lower half corrupt a single pattern each, which keeps key-pruning search slow. Nearly every other key corrupts about half of the patterns.

There are no states or transitions. The only "modes" are the key regions:
- the correct key;
- a silenced booster with a wrong lower half;
- an active booster with the correct lower half;
- an active booster with a wrong lower half.

Top module: `lock_wrap`

## Requirements
- R1: The key port is split in two halves. Bits `key_in[N-1:0]` form the lower half, and bit i of that half is paired with `x_in[i]`. Bits `key_in[2N-1:N]` form the upper half.
- R2: With the upper key half equal to `SEL_KEY`, the locked bit differs from the plain bit for exactly one input: `x_in == lower_half ^ ~PMASK`. PMASK bit value 1 selects an XNOR pairing and 0 selects an XOR pairing. The one exception is given in R3.
- R3: When `x_in == HIDE_PAT`, the point unit never flips the output, whatever the lower key half.
- R4: When the upper key half is not `SEL_KEY`, the booster flips exactly when `x_in[TAP] ^ upper_half[KTAP] ^ BPOL` is 1. BPOL value 1 means XNOR. When the upper half equals `SEL_KEY`, the booster never flips.
- R5: The output is `y_locked = y_plain ^ point_flip ^ booster_flip`. An input on which both units fire therefore leaves the output uncorrupted.
- R6: The key `{SEL_KEY, HIDE_PAT ^ ~PMASK}` gives `y_locked == y_plain` for every input and both plain values. It is the only key that does so.
- R7: Over the whole key space, the number of corrupted inputs per key is distributed as follows:
  - 2^N−1 keys corrupt exactly 1 input;
  - 2^N−1 keys corrupt 2^(N−1) inputs;
  - 2^(2N)−2^(N+1)+1 keys corrupt either 2^(N−1)+1 or 2^(N−1)−1 inputs;
  - 1 key corrupts none.
- R8: The locked output responds combinationally. A change on `y_plain` shows on `y_locked` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | N | Primary input vector of the protected circuit |
| key_in | input | 2N | Key; lower half feeds the point unit, upper half the booster |
| y_plain | input | 1 | Unlocked output bit of the protected circuit |
| y_locked | output | 1 | Locked output bit |

## Verification
The block holds no state, so a wrong internal term shows on `y_locked` immediately, in the same evaluation as the input change. A wrong polarity or pattern term in the point unit moves or removes a single corrupted input. That shows up only as a one-pattern mismatch under a silenced booster, which is why every input is swept for such keys. A wrong selected-key compare or wrong tap in the booster changes roughly half of all patterns for a key. A fault in the merge gate breaks the cancellation input and shifts the per-key corruption histogram away from the expected counts.

// File: rtl/lock_wrap_pkg.sv
package lock_wrap_pkg;

    typedef enum logic {
        GATE_XOR  = 1'b0,
        GATE_XNOR = 1'b1
    } gate_pol_e;

    // Pairwise key/input comparison gate with selectable polarity.
    function automatic logic pol_gate(input logic a, input logic b, input gate_pol_e pol);
        logic d;
        d = a ^ b;
        return (pol == GATE_XNOR) ? ~d : d;
    endfunction

endpackage

// File: rtl/point_unit.sv
module point_unit
    import lock_wrap_pkg::*;
#(
    parameter int unsigned    N     = 4,
    parameter logic [N-1:0]   PMASK = '0,
    parameter logic [N-1:0]   HIDE  = '0
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] k_lo,
    output logic         fire
);

    logic [N-1:0] bit_ok;
    logic         hide_miss;

    // One polarity-selected comparator per input bit.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam gate_pol_e BIT_POL = gate_pol_e'(PMASK[i]);
        always_comb bit_ok[i] = pol_gate(x[i], k_lo[i], BIT_POL);
    end

    // NAND of the hidden-pattern match keeps the unit quiet on that pattern.
    always_comb hide_miss = ~(x == HIDE);
    always_comb fire      = (&bit_ok) & hide_miss;

endmodule

// File: rtl/boost_unit.sv
module boost_unit
    import lock_wrap_pkg::*;
#(
    parameter int unsigned    N     = 4,
    parameter int unsigned    KTAP  = 0,
    parameter logic           BPOL  = 1'b0,
    parameter logic [N-1:0]   SEL   = '0
) (
    input  logic         x_tap,
    input  logic [N-1:0] k_hi,
    output logic         flip
);

    localparam gate_pol_e TAP_POL = gate_pol_e'(BPOL);

    logic tap_term;
    logic key_open;

    always_comb tap_term = pol_gate(x_tap, k_hi[KTAP], TAP_POL);
    // Low only for the selected key: silences the booster entirely.
    always_comb key_open = ~(k_hi == SEL);
    always_comb flip     = tap_term & key_open;

endmodule

// File: rtl/lock_wrap.sv
module lock_wrap #(
    parameter int unsigned    N        = 4,
    parameter logic [N-1:0]   PMASK    = 4'b1010,
    parameter logic [N-1:0]   HIDE_PAT = 4'b1001,
    parameter int unsigned    TAP      = 2,
    parameter int unsigned    KTAP     = 1,
    parameter logic           BPOL     = 1'b1,
    parameter logic [N-1:0]   SEL_KEY  = 4'b0110
) (
    input  logic [N-1:0]   x_in,
    input  logic [2*N-1:0] key_in,
    input  logic           y_plain,
    output logic           y_locked
);

    localparam int unsigned      KW          = 2 * N;
    localparam logic [N-1:0]     K_LO_GOOD   = HIDE_PAT ^ ~PMASK;
    localparam logic [KW-1:0]    CORRECT_KEY = {SEL_KEY, K_LO_GOOD};

    logic [N-1:0] k_lo;
    logic [N-1:0] k_hi;
    logic         point_flip;
    logic         boost_flip;
    logic         flip;

    always_comb begin
        k_lo = key_in[N-1:0];
        k_hi = key_in[KW-1:N];
    end

    point_unit #(
        .N     (N),
        .PMASK (PMASK),
        .HIDE  (HIDE_PAT)
    ) u_point (
        .x    (x_in),
        .k_lo (k_lo),
        .fire (point_flip)
    );

    boost_unit #(
        .N    (N),
        .KTAP (KTAP),
        .BPOL (BPOL),
        .SEL  (SEL_KEY)
    ) u_boost (
        .x_tap (x_in[TAP]),
        .k_hi  (k_hi),
        .flip  (boost_flip)
    );

    // XOR merge: coinciding firings cancel instead of gating each other.
    always_comb flip     = point_flip ^ boost_flip;
    always_comb y_locked = y_plain ^ flip;

    always_comb begin
        if (!$isunknown({x_in, key_in, y_plain})) begin
            assert_point_pattern_R2: assert (!point_flip || ((x_in ^ k_lo) == ~PMASK))
                else $error("point unit fired off its matched pattern");
            assert_hide_quiet_R3: assert (!(point_flip && (x_in == HIDE_PAT)))
                else $error("point unit fired on hidden pattern");
            assert_boost_silenced_R4: assert (!(boost_flip && (k_hi == SEL_KEY)))
                else $error("booster fired under selected key");
            assert_correct_key_clean_R6: assert ((key_in != CORRECT_KEY) || (y_locked == y_plain))
                else $error("correct key corrupted the output");
        end
    end

endmodule

// File: tb/lock_wrap_test.sv
module lock_wrap_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int KW = 2 * N;
    localparam logic [N-1:0] PM = 4'b1010;
    localparam logic [N-1:0] HP = 4'b1001;
    localparam int TP = 2;
    localparam int KT = 1;
    localparam logic BP = 1'b1;
    localparam logic [N-1:0] SK = 4'b0110;
    localparam logic [KW-1:0] GOOD_KEY = {SK, HP ^ ~PM};

    logic clk = 1'b0;
    logic [N-1:0]  x_in = '0;
    logic [KW-1:0] key_in = '0;
    logic          y_plain = 1'b0;
    logic          y_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_wrap #(
        .N(N), .PMASK(PM), .HIDE_PAT(HP), .TAP(TP), .KTAP(KT), .BPOL(BP), .SEL_KEY(SK)
    ) uut (
        .x_in(x_in), .key_in(key_in), .y_plain(y_plain), .y_locked(y_locked)
    );

    // Expected flip from the requirement formulas (R1..R5).
    function automatic logic exp_flip(logic [N-1:0] x, logic [KW-1:0] k);
        logic [N-1:0] lo, hi;
        logic pt, bs;
        lo = k[N-1:0];
        hi = k[KW-1:N];
        pt = (x == (lo ^ ~PM)) && (x != HP);
        bs = (hi != SK) && (x[TP] ^ hi[KT] ^ BP);
        return pt ^ bs;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [N-1:0] x, logic [KW-1:0] k, logic yo);
        @(negedge clk);
        x_in = x; key_in = k; y_plain = yo;
        #1;
    endtask

    // Initial check: correct key passes the plain bit on both values.
    task automatic t_start_state();
        apply('0, GOOD_KEY, 1'b0);
        check(y_locked == 1'b0, "R6 start yo=0", y_locked, 0);
        #1 y_plain = 1'b1; #1;
        check(y_locked == 1'b1, "R6 start yo=1", y_locked, 1);
    endtask

    // Point unit alone (booster silenced): single flip at matched pattern.
    task automatic t_point_unit();
        logic [N-1:0] los[4] = '{4'b0000, 4'b1111, 4'b0110, HP ^ ~PM};
        foreach (los[j]) begin
            int hits = 0;
            for (int xv = 0; xv < (1 << N); xv++) begin
                logic e;
                apply(xv[N-1:0], {SK, los[j]}, xv[0]);
                e = ((xv[N-1:0] ^ los[j]) == ~PM) && (xv[N-1:0] != HP);
                check((y_locked ^ y_plain) == e, "R2 point pattern", y_locked ^ y_plain, e);
                if (y_locked ^ y_plain) hits++;
            end
            check(hits == ((los[j] == (HP ^ ~PM)) ? 0 : 1), "R1 one flip per lower half", hits,
                  (los[j] == (HP ^ ~PM)) ? 0 : 1);
        end
    endtask

    // Hidden pattern: no point flip for any lower half while booster silenced.
    task automatic t_hidden();
        for (int lo = 0; lo < (1 << N); lo++) begin
            apply(HP, {SK, lo[N-1:0]}, 1'b1);
            check(y_locked == 1'b1, "R3 hidden pattern quiet", y_locked, 1);
        end
    endtask

    // Booster alone (correct lower half): tap-driven half flip.
    task automatic t_booster();
        logic [N-1:0] his[3] = '{4'b0000, 4'b0010, 4'b1111};
        foreach (his[j]) begin
            int hits = 0;
            for (int xv = 0; xv < (1 << N); xv++) begin
                logic e;
                apply(xv[N-1:0], {his[j], HP ^ ~PM}, 1'b0);
                e = xv[TP] ^ his[j][KT] ^ BP;
                check(y_locked == e, "R4 booster tap", y_locked, e);
                if (y_locked) hits++;
            end
            check(hits == (1 << (N-1)), "R4 booster half", hits, 1 << (N-1));
        end
    endtask

    // Both units fire on the same input: they cancel.
    task automatic t_cancel();
        // upper 0000: booster fires when x[2]==0; lower 0110 matches x=0011
        apply(4'b0011, {4'b0000, 4'b0110}, 1'b1);
        check(y_locked == 1'b1, "R5 xor cancel", y_locked, 1);
        apply(4'b0111, {4'b0000, 4'b0110}, 1'b1);
        check(y_locked == 1'b1, "R5 neither fires", y_locked, 1);
        apply(4'b0001, {4'b0000, 4'b0110}, 1'b1);
        check(y_locked == 1'b0, "R5 booster only", y_locked, 0);
    endtask

    // Combinational response: plain bit toggles within a clock low phase.
    task automatic t_comb();
        apply(4'b0101, GOOD_KEY, 1'b0);
        check(y_locked == 1'b0, "R8 comb before", y_locked, 0);
        y_plain = 1'b1; #1;
        check(y_locked == 1'b1, "R8 comb after", y_locked, 1);
        key_in = {4'b0000, HP ^ ~PM}; x_in = 4'b0000; #1;
        check(y_locked == 1'b0, "R8 comb key change", y_locked, 0);
    endtask

    // Exhaustive sweep: per-key corruption counts and histogram.
    task automatic t_distribution();
        int c_zero = 0, c_one = 0, c_half = 0, c_pm = 0, c_other = 0;
        int zero_key = -1;
        for (int kv = 0; kv < (1 << KW); kv++) begin
            int cnt = 0, ecnt = 0;
            for (int xv = 0; xv < (1 << N); xv++) begin
                logic yo;
                yo = ^{xv[N-1:0], kv[2:0]};
                apply(xv[N-1:0], kv[KW-1:0], yo);
                if (y_locked != y_plain) cnt++;
                if (exp_flip(xv[N-1:0], kv[KW-1:0])) ecnt++;
            end
            check(cnt == ecnt, "R7 per-key count", cnt, ecnt);
            if (cnt == 0) begin c_zero++; zero_key = kv; end
            else if (cnt == 1) c_one++;
            else if (cnt == (1 << (N-1))) c_half++;
            else if (cnt == (1 << (N-1)) + 1 || cnt == (1 << (N-1)) - 1) c_pm++;
            else c_other++;
        end
        check(c_zero == 1, "R6 unique clean key", c_zero, 1);
        check(zero_key == int'(GOOD_KEY), "R6 clean key value", zero_key, int'(GOOD_KEY));
        check(c_one == (1 << N) - 1, "R7 one-flip keys", c_one, (1 << N) - 1);
        check(c_half == (1 << N) - 1, "R7 half-flip keys", c_half, (1 << N) - 1);
        check(c_pm == (1 << KW) - (1 << (N+1)) + 1, "R7 near-half keys", c_pm,
              (1 << KW) - (1 << (N+1)) + 1);
        check(c_other == 0, "R7 no other counts", c_other, 0);
    endtask

    initial begin
        t_start_state();
        t_point_unit();
        t_hidden();
        t_booster();
        t_cancel();
        t_comb();
        t_distribution();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule